// File: doc/BRIEF.md
# Multiple Header Recording Error Log

This block keeps the uncorrectable error status register of an error-reporting function together with the logs that describe the first error still pending. Each logged error has a first-error pointer (the bit index of its status bit), a four-dword header log and an optional four-dword prefix log. When software enables multiple header recording, errors that arrive while the first one is still unserviced are not lost. They wait in a small queue, and each one is loaded into the logs in turn as software clears the status bit that the pointer names.

An upstream detector drives a record strobe carrying a one-hot status vector, the raw header and prefix dwords, and two flags that say whether those dwords are meaningful. Software writes to the status register, which is write-one-to-clear. The block then either advances to the next queued record, wipes the logs, or restores status bits so that no queued error disappears. When the queue is full, a new error is dropped and a one-cycle overflow pulse goes out. The neighbouring logic reports that pulse as a correctable header-log-overflow error.

Top module: `mhr_err_log`

## Requirements
- R1: After reset, the status register, first-error pointer, prefix-logged bit, header log, prefix log and overflow pulse are all zero.
- R2: A record strobe whose status vector has zero bits or more than one bit set changes no output in the following cycle.
- R3: A legal record (exactly one status bit set) sets that status bit one cycle later. If recording is disabled, or the status bit at the current pointer is clear, the pointer is loaded with the index of that bit in the same cycle.
- R4: On a load, header dword k (bits 32k+31..32k of the header input) is stored in the header log at the same position with its four bytes reversed. If the header-valid flag is clear, the header log is zero.
- R5: On a load, the prefix log receives the prefix dwords, byte-reversed like the header, and the prefix-logged bit is set, but only when the prefix-present flag and the prefix-capability input are both 1. Otherwise the prefix log is zero and the bit is clear.
- R6: With recording enabled and the status bit at the pointer set, a legal record is queued. The pointer and both logs stay unchanged, and the record's status bit is still set.
- R7: With the queue full (FIFO_DEPTH entries), a record that would be queued is dropped. Its status bit is still set, and ovf_o is high for exactly the one cycle after the strobe.
- R8: A status write that leaves the pointer's bit clear, while recording is enabled and the queue is non-empty, sets again the status bit of every queued record. It pops the oldest record and loads the pointer and logs from it.
- R9: A status write that leaves the pointer's bit clear, while the queue is empty or recording is disabled, clears the pointer, the prefix-logged bit, the header log and the prefix log.
- R10: A status write that leaves the pointer's bit set while recording is enabled sets again the status bits of all queued records and leaves the pointer and logs unchanged.
- R11: A status write that leaves the pointer's bit set while recording is disabled empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Error record strobe |
| rec_sts_i | input | 32 | One-hot uncorrectable status bit of the record |
| rec_hdr_vld_i | input | 1 | Header dwords are valid |
| rec_pfx_vld_i | input | 1 | Prefix dwords are present |
| rec_hdr_i | input | 128 | Four raw header dwords, dword k at bits 32k+31..32k |
| rec_pfx_i | input | 128 | Four raw prefix dwords, same layout |
| pfx_cap_i | input | 1 | Device supports end-to-end prefixes |
| mhr_en_i | input | 1 | Multiple header recording enable |
| sts_wr_i | input | 1 | Write strobe to the status register |
| sts_wdata_i | input | 32 | Write data, ones clear bits |
| sts_o | output | 32 | Uncorrectable status register |
| fep_o | output | 5 | First-error pointer |
| pfx_bit_o | output | 1 | Prefix log holds valid data |
| hdr_log_o | output | 128 | Header log |
| pfx_log_o | output | 128 | Prefix log |
| ovf_o | output | 1 | Header log overflow pulse |

## Verification
A corrupted queue count or a shifted queue slot does not show at once. It appears only when software clears the pointer's bit, as a wrong pointer or a wrong header in the next cycle, or as a status bit that fails to come back after a partial clear. The bench therefore fills the queue to full, overflows it, drains it in order and flushes it. After each write it compares the pointer, the header log and the status register one cycle later. A bad byte order or a bad flag gate shows on the very next load, so each load is checked against header and prefix data that differ per record.

// File: rtl/mhr_pkg.sv
package mhr_pkg;
  localparam int STS_W = 32;
  localparam int FEP_W = $clog2(STS_W);
  localparam int DW    = 32;
  localparam int NDW   = 4;
  localparam int LOG_W = DW * NDW;

  typedef struct packed {
    logic [STS_W-1:0] sts;
    logic             hdr_vld;
    logic             pfx_vld;
    logic [LOG_W-1:0] hdr;
    logic [LOG_W-1:0] pfx;
  } mhr_rec_t;

  function automatic logic [DW-1:0] byte_rev(input logic [DW-1:0] d);
    logic [DW-1:0] r;
    for (int b = 0; b < DW/8; b++) r[8*b +: 8] = d[8*(DW/8-1-b) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/mhr_onehot.sv
module mhr_onehot #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          legal_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++)
      if (vec_i[i]) idx_o = IW'(i);
  end

  assign legal_o = (vec_i != '0) && ((vec_i & (vec_i - W'(1))) == '0);
endmodule

// File: rtl/mhr_fifo.sv
module mhr_fifo import mhr_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  mhr_rec_t         din_i,
  output mhr_rec_t         head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [STS_W-1:0] sts_or_o
);
  mhr_rec_t       mem [DEPTH];
  logic [CW-1:0]  cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (flush_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
  end

  // slot 0 is always the oldest entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i < DEPTH - 1) begin : g_mid
      always_ff @(posedge clk_i) begin
        if (pop_i) begin
          if (push_i && CW'(i + 1) == cnt_q) mem[i] <= din_i;
          else                               mem[i] <= mem[i+1];
        end else if (push_i && CW'(i) == cnt_q) begin
          mem[i] <= din_i;
        end
      end
    end else begin : g_last
      always_ff @(posedge clk_i) begin
        if (push_i && ((pop_i && CW'(i + 1) == cnt_q) || (!pop_i && CW'(i) == cnt_q)))
          mem[i] <= din_i;
      end
    end
  end

  always_comb begin
    sts_or_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (CW'(i) < cnt_q) sts_or_o = sts_or_o | mem[i].sts;
  end
endmodule

// File: rtl/mhr_log_fmt.sv
module mhr_log_fmt import mhr_pkg::*; (
  input  mhr_rec_t         rec_i,
  input  logic             cap_i,
  output logic [LOG_W-1:0] hdr_o,
  output logic [LOG_W-1:0] pfx_o,
  output logic             pfx_bit_o
);
  assign pfx_bit_o = rec_i.pfx_vld && cap_i;

  for (genvar k = 0; k < NDW; k++) begin : g_dw
    assign hdr_o[k*DW +: DW] = rec_i.hdr_vld ? byte_rev(rec_i.hdr[k*DW +: DW]) : '0;
    assign pfx_o[k*DW +: DW] = pfx_bit_o     ? byte_rev(rec_i.pfx[k*DW +: DW]) : '0;
  end
endmodule

// File: rtl/mhr_err_log.sv
module mhr_err_log import mhr_pkg::*; #(
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rec_valid_i,
  input  logic [STS_W-1:0] rec_sts_i,
  input  logic             rec_hdr_vld_i,
  input  logic             rec_pfx_vld_i,
  input  logic [LOG_W-1:0] rec_hdr_i,
  input  logic [LOG_W-1:0] rec_pfx_i,
  input  logic             pfx_cap_i,
  input  logic             mhr_en_i,
  input  logic             sts_wr_i,
  input  logic [STS_W-1:0] sts_wdata_i,
  output logic [STS_W-1:0] sts_o,
  output logic [FEP_W-1:0] fep_o,
  output logic             pfx_bit_o,
  output logic [LOG_W-1:0] hdr_log_o,
  output logic [LOG_W-1:0] pfx_log_o,
  output logic             ovf_o
);
  logic [STS_W-1:0] sts_q, sts_w, sts_a, q_or;
  logic [FEP_W-1:0] fep_q, fep_a, fep_d, rec_idx, head_idx, ld_idx;
  logic             pfx_bit_q, ovf_q;
  logic [LOG_W-1:0] hdr_q, pfx_q, fmt_hdr, fmt_pfx;
  logic             fmt_pfx_bit;
  logic             rec_legal, head_legal, q_empty, q_full;
  logic             ptr_clr, pop, clr_log, flush, rec_go, hold, push, ovf_d, load_rec, load;
  mhr_rec_t         rec_in, head, ld_src;

  assign rec_in = '{sts: rec_sts_i, hdr_vld: rec_hdr_vld_i, pfx_vld: rec_pfx_vld_i,
                    hdr: rec_hdr_i, pfx: rec_pfx_i};

  mhr_onehot #(.W(STS_W), .IW(FEP_W)) u_rec_dec (
    .vec_i(rec_sts_i), .legal_o(rec_legal), .idx_o(rec_idx));

  mhr_onehot #(.W(STS_W), .IW(FEP_W)) u_head_dec (
    .vec_i(head.sts), .legal_o(head_legal), .idx_o(head_idx));

  mhr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop), .flush_i(flush),
    .din_i(rec_in), .head_o(head), .empty_o(q_empty), .full_o(q_full), .sts_or_o(q_or));

  // status write applied first, then the record sees the post-write state
  always_comb begin
    sts_w    = sts_q & ~sts_wdata_i;
    ptr_clr  = sts_wr_i && !sts_w[fep_q];
    pop      = ptr_clr && mhr_en_i && !q_empty;
    clr_log  = ptr_clr && !pop;
    flush    = sts_wr_i && !ptr_clr && !mhr_en_i;
    sts_a    = sts_wr_i ? (sts_w | (mhr_en_i ? q_or : '0)) : sts_q;
    fep_a    = pop ? head_idx : (clr_log ? '0 : fep_q);
    rec_go   = rec_valid_i && rec_legal;
    hold     = rec_go && mhr_en_i && sts_a[fep_a];
    push     = hold && (!q_full || pop);
    ovf_d    = hold && q_full && !pop;
    load_rec = rec_go && !hold;
    load     = load_rec || (pop && head_legal);
    ld_src   = load_rec ? rec_in : head;
    ld_idx   = load_rec ? rec_idx : head_idx;
    fep_d    = load ? ld_idx : fep_a;
  end

  mhr_log_fmt u_fmt (
    .rec_i(ld_src), .cap_i(pfx_cap_i),
    .hdr_o(fmt_hdr), .pfx_o(fmt_pfx), .pfx_bit_o(fmt_pfx_bit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q     <= '0;
      fep_q     <= '0;
      pfx_bit_q <= 1'b0;
      hdr_q     <= '0;
      pfx_q     <= '0;
      ovf_q     <= 1'b0;
    end else begin
      sts_q <= sts_a | (rec_go ? rec_sts_i : '0);
      fep_q <= fep_d;
      ovf_q <= ovf_d;
      if (load) begin
        hdr_q     <= fmt_hdr;
        pfx_q     <= fmt_pfx;
        pfx_bit_q <= fmt_pfx_bit;
      end else if (clr_log) begin
        hdr_q     <= '0;
        pfx_q     <= '0;
        pfx_bit_q <= 1'b0;
      end
    end
  end

  assign sts_o     = sts_q;
  assign fep_o     = fep_q;
  assign pfx_bit_o = pfx_bit_q;
  assign hdr_log_o = hdr_q;
  assign pfx_log_o = pfx_q;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/mhr_err_log_chk.sv
module mhr_err_log_chk import mhr_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rec_valid_i,
  input logic [STS_W-1:0] rec_sts_i,
  input logic             mhr_en_i,
  input logic             sts_wr_i,
  input logic [STS_W-1:0] sts_wdata_i,
  input logic [STS_W-1:0] sts_o,
  input logic [FEP_W-1:0] fep_o,
  input logic             pfx_bit_o,
  input logic [LOG_W-1:0] hdr_log_o,
  input logic [LOG_W-1:0] pfx_log_o,
  input logic             ovf_o
);
  logic ptr_kept;
  assign ptr_kept = |((sts_o & ~sts_wdata_i) & (STS_W'(1) << fep_o));

  a_r2_illegal_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && $countones(rec_sts_i) != 1 && !sts_wr_i
    |=> $stable(sts_o) && $stable(fep_o) && $stable(hdr_log_o) && !ovf_o);

  a_r3_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && $countones(rec_sts_i) == 1 && !mhr_en_i && !sts_wr_i
    |=> ((STS_W'(1) << fep_o) == $past(rec_sts_i)) && ((sts_o & $past(rec_sts_i)) != '0));

  a_r5_pfx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pfx_bit_o |-> pfx_log_o == '0);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && $countones(rec_sts_i) == 1 && mhr_en_i && sts_o[fep_o] && !sts_wr_i
    |=> $stable(fep_o) && $stable(hdr_log_o) && $stable(pfx_log_o));

  a_r7_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(rec_valid_i && mhr_en_i));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr_i && !mhr_en_i && !rec_valid_i && !ptr_kept
    |=> fep_o == '0 && hdr_log_o == '0 && pfx_log_o == '0 && !pfx_bit_o);

  a_r10_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr_i && mhr_en_i && !rec_valid_i && ptr_kept
    |=> $stable(fep_o) && $stable(hdr_log_o) && $stable(pfx_log_o));
endmodule

bind mhr_err_log mhr_err_log_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rec_valid_i(rec_valid_i), .rec_sts_i(rec_sts_i),
  .mhr_en_i(mhr_en_i), .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i),
  .sts_o(sts_o), .fep_o(fep_o), .pfx_bit_o(pfx_bit_o), .hdr_log_o(hdr_log_o),
  .pfx_log_o(pfx_log_o), .ovf_o(ovf_o));

// File: tb/sim_mhr_err_log.sv
module sim_mhr_err_log;
  localparam int DEPTH = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         rec_valid_i = 1'b0;
  logic [31:0]  rec_sts_i = '0;
  logic         rec_hdr_vld_i = 1'b0;
  logic         rec_pfx_vld_i = 1'b0;
  logic [127:0] rec_hdr_i = '0;
  logic [127:0] rec_pfx_i = '0;
  logic         pfx_cap_i = 1'b0;
  logic         mhr_en_i = 1'b0;
  logic         sts_wr_i = 1'b0;
  logic [31:0]  sts_wdata_i = '0;
  logic [31:0]  sts_o;
  logic [4:0]   fep_o;
  logic         pfx_bit_o;
  logic [127:0] hdr_log_o;
  logic [127:0] pfx_log_o;
  logic         ovf_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  mhr_err_log #(.FIFO_DEPTH(DEPTH)) u0 (.*);

  typedef struct packed {
    logic [31:0] sts;
    logic        hv;
    logic        pv;
    logic        cap;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0010, 1'b1, 1'b1, 1'b1},
    '{32'h0000_0000, 1'b1, 1'b1, 1'b1},
    '{32'h0000_0300, 1'b1, 1'b0, 1'b0},
    '{32'h8000_0000, 1'b0, 1'b1, 1'b1},
    '{32'h0000_0001, 1'b1, 1'b1, 1'b0},
    '{32'h0002_0000, 1'b1, 1'b0, 1'b1}
  };

  function automatic logic [127:0] mk_data(input int seed);
    logic [127:0] d;
    for (int k = 0; k < 4; k++) d[32*k +: 32] = {8'(seed), 8'(k + 1), 8'h5A, 8'hC3};
    return d;
  endfunction

  function automatic logic [127:0] swap_dw(input logic [127:0] d);
    logic [127:0] r;
    for (int k = 0; k < 4; k++)
      r[32*k +: 32] = {d[32*k +: 8], d[32*k+8 +: 8], d[32*k+16 +: 8], d[32*k+24 +: 8]};
    return r;
  endfunction

  function automatic int bit_idx(input logic [31:0] v);
    int r = 0;
    for (int i = 0; i < 32; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic int ones(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_rec(input logic [31:0] s, input logic hv, input logic pv, input logic cap,
                        input int seed);
    @(negedge clk_i);
    rec_valid_i = 1'b1; rec_sts_i = s; rec_hdr_vld_i = hv; rec_pfx_vld_i = pv;
    pfx_cap_i = cap; rec_hdr_i = mk_data(seed); rec_pfx_i = mk_data(seed + 50);
    @(negedge clk_i);
    rec_valid_i = 1'b0;
  endtask

  task automatic do_wr(input logic [31:0] w);
    @(negedge clk_i);
    sts_wr_i = 1'b1; sts_wdata_i = w;
    @(negedge clk_i);
    sts_wr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0]  e_sts;
    logic [4:0]   e_fep;
    logic [127:0] e_hdr, e_pfx;
    logic         e_pb;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 sts", 128'(sts_o), 128'(0));
    chk("R1 fep", 128'(fep_o), 128'(0));
    chk("R1 logs", hdr_log_o | pfx_log_o, 128'(0));
    chk("R1 pfx_bit/ovf", 128'({pfx_bit_o, ovf_o}), 128'(0));
    rst_ni = 1'b1;

    // table: recording disabled, every legal record loads
    e_sts = '0; e_fep = '0; e_hdr = '0; e_pfx = '0; e_pb = 1'b0;
    for (int v = 0; v < 6; v++) begin
      do_rec(VECS[v].sts, VECS[v].hv, VECS[v].pv, VECS[v].cap, v + 10);
      if (ones(VECS[v].sts) == 1) begin
        e_sts = e_sts | VECS[v].sts;
        e_fep = 5'(bit_idx(VECS[v].sts));
        e_hdr = VECS[v].hv ? swap_dw(mk_data(v + 10)) : '0;
        e_pb  = VECS[v].pv && VECS[v].cap;
        e_pfx = e_pb ? swap_dw(mk_data(v + 60)) : '0;
        chk("R3 sts", 128'(sts_o), 128'(e_sts));
        chk("R3 fep", 128'(fep_o), 128'(e_fep));
        chk("R4 hdr_log", hdr_log_o, e_hdr);
        chk("R5 pfx_log", pfx_log_o, e_pfx);
        chk("R5 pfx_bit", 128'(pfx_bit_o), 128'(e_pb));
      end else begin
        chk("R2 sts", 128'(sts_o), 128'(e_sts));
        chk("R2 fep", 128'(fep_o), 128'(e_fep));
        chk("R2 hdr_log", hdr_log_o, e_hdr);
        chk("R2 pfx_log", pfx_log_o, e_pfx);
        chk("R2 ovf", 128'(ovf_o), 128'(0));
      end
    end

    // R9: clear everything with recording disabled
    do_wr(32'hFFFF_FFFF);
    chk("R9 sts", 128'(sts_o), 128'(0));
    chk("R9 fep", 128'(fep_o), 128'(0));
    chk("R9 logs", hdr_log_o | pfx_log_o, 128'(0));
    chk("R9 pfx_bit", 128'(pfx_bit_o), 128'(0));

    // queued operation
    mhr_en_i = 1'b1;
    do_rec(32'h0000_0020, 1'b1, 1'b1, 1'b1, 105);
    chk("R3 fep mhr", 128'(fep_o), 128'(5));
    do_rec(32'h0000_1000, 1'b1, 1'b1, 1'b1, 112);
    do_rec(32'h0000_0080, 1'b1, 1'b0, 1'b1, 107);
    chk("R6 fep held", 128'(fep_o), 128'(5));
    chk("R6 hdr held", hdr_log_o, swap_dw(mk_data(105)));
    chk("R6 pfx held", pfx_log_o, swap_dw(mk_data(155)));
    chk("R6 sts", 128'(sts_o), 128'(32'h0000_10A0));

    do_wr(32'h0000_1000);
    chk("R10 sts restored", 128'(sts_o), 128'(32'h0000_10A0));
    chk("R10 fep", 128'(fep_o), 128'(5));

    do_wr(32'h0000_0020);
    chk("R8 sts", 128'(sts_o), 128'(32'h0000_1080));
    chk("R8 fep", 128'(fep_o), 128'(12));
    chk("R8 hdr", hdr_log_o, swap_dw(mk_data(112)));
    chk("R8 pfx", pfx_log_o, swap_dw(mk_data(162)));

    do_wr(32'h0000_1000);
    chk("R8 fep 2nd", 128'(fep_o), 128'(7));
    chk("R8 hdr 2nd", hdr_log_o, swap_dw(mk_data(107)));
    chk("R8 pfx_bit 2nd", 128'(pfx_bit_o), 128'(0));
    chk("R8 sts 2nd", 128'(sts_o), 128'(32'h0000_0080));

    do_wr(32'h0000_0080);
    chk("R9 empty sts", 128'(sts_o), 128'(0));
    chk("R9 empty fep", 128'(fep_o), 128'(0));
    chk("R9 empty hdr", hdr_log_o, 128'(0));

    // R7 overflow
    do_rec(32'h0000_0001, 1'b1, 1'b0, 1'b0, 100);
    for (int b = 1; b <= DEPTH; b++) begin
      do_rec(32'(1) << b, 1'b1, 1'b0, 1'b0, 100 + b);
      chk("R7 no ovf while filling", 128'(ovf_o), 128'(0));
    end
    do_rec(32'(1) << (DEPTH + 1), 1'b1, 1'b0, 1'b0, 100 + DEPTH + 1);
    chk("R7 ovf pulse", 128'(ovf_o), 128'(1));
    chk("R7 sts", 128'(sts_o), 128'(32'h0000_03FF));
    chk("R7 fep kept", 128'(fep_o), 128'(0));
    @(negedge clk_i);
    chk("R7 ovf one cycle", 128'(ovf_o), 128'(0));

    do_wr(32'h0000_0001);
    chk("R8 oldest first", 128'(fep_o), 128'(1));
    chk("R8 oldest hdr", hdr_log_o, swap_dw(mk_data(101)));
    chk("R8 sts after pop", 128'(sts_o), 128'(32'h0000_03FE));

    // R11 flush with recording disabled
    mhr_en_i = 1'b0;
    do_wr(32'h0000_0000);
    chk("R11 sts unchanged", 128'(sts_o), 128'(32'h0000_03FE));
    mhr_en_i = 1'b1;
    do_wr(32'h0000_0002);
    chk("R11 queue emptied fep", 128'(fep_o), 128'(0));
    chk("R11 queue emptied hdr", hdr_log_o, 128'(0));
    chk("R11 sts", 128'(sts_o), 128'(32'h0000_03FC));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule